// File: doc/BRIEF.md
# Motor PWM Carrier Timebase

This block generates the carrier for one motor-drive PWM channel. A prescaler divides the clock into counter ticks. A 16-bit counter runs against a programmable period in one of two modes. In edge mode it counts up and wraps. In center mode it counts up to the period and then back down. One raw PWM output is high while the count is below the active compare value.

Period and compare values are written into shadow copies. The counter uses active copies, which are refreshed only when a new carrier cycle begins, so a write issued mid-cycle never cuts a pulse short. The mode select is taken at the same point. Each cycle start produces a one-clock update pulse. When the block is the master, that pulse is also driven on a trigger output. When the block is a slave, a sync input restarts its carrier, so several timers can share one phase.

Top module: `pwm_timebase`

## Requirements
- R1: In edge mode (center_i=0) the count runs 0,1,...,P and then returns to 0, so a carrier cycle lasts P+1 ticks, where P is the active period.
- R2: Each tick lasts psc_i+1 clocks. With psc_i=0 the counter advances on every clock.
- R3: Values written with wr_per_i or wr_cmp_i (data on wdata_i) change nothing in the cycle that is running. They become active at the next cycle start.
- R4: pwm_o is high exactly while the count is less than the active compare value. In edge mode this gives C high ticks per cycle for 0<C<=P.
- R5: In center mode (center_i=1) with P>=2 the count runs 0,1,...,P,P-1,...,1, which is 2P ticks, and the cycle starts when the count returns to 0. With C<=P the output is high for 2C-1 ticks per cycle.
- R6: A compare value of 0 keeps pwm_o low for the whole cycle. A compare value greater than P keeps it high for the whole cycle.
- R7: update_o pulses for one clock in the first clock of each new cycle, while cnt_o shows 0.
- R8: With master_i=1, trig_o pulses together with update_o. With master_i=0, trig_o stays low.
- R9: With master_i=0, sync_i high for one clock restarts the carrier: on the next clock cnt_o is 0, update_o is high and the shadow values are loaded. With master_i=1, sync_i is ignored.
- R10: One clock after en_i goes low, cnt_o is 0 and pwm_o is low. While disabled, shadow values pass straight to the active copies, so the first cycle after enable uses them. The count starts at 0 one clock after en_i rises.
- R11: A change of center_i takes effect only at the next cycle start.
- R12: After reset, cnt_o is 0 and pwm_o, update_o and trig_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Run enable |
| center_i | input | 1 | 0 = edge mode, 1 = center mode |
| master_i | input | 1 | 1 = master (drives trigger), 0 = slave (follows sync) |
| psc_i | input | 16 | Prescale divisor minus one |
| wr_per_i | input | 1 | Write wdata_i to the period shadow |
| wr_cmp_i | input | 1 | Write wdata_i to the compare shadow |
| wdata_i | input | 16 | Write data |
| sync_i | input | 1 | External carrier restart (slave only) |
| pwm_o | output | 1 | Raw PWM output |
| cnt_o | output | 16 | Current count |
| update_o | output | 1 | Cycle-start pulse |
| trig_o | output | 1 | Trigger to other timers (master only) |

## Verification
Some properties are checked on every cycle by assertions. The count never exceeds the active period. Down-counting occurs only in center mode. The active values stay constant unless a load occurs. An update pulse always coincides with a zero count. The compare extremes force the output low or high. The trigger never fires without an update. A disabled block shows a zero count and a low output.

Other behaviour shows only across whole cycles, so the bench's scenarios cover it. These include cycle lengths in both modes and the high-tick counts. They also cover prescaled tick widths and the cycle in which a mid-cycle write or mode change first shows. The slave restart, with the master ignoring sync, and the first cycle after enable are checked the same way.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  typedef enum logic {MODE_EDGE = 1'b0, MODE_CENTER = 1'b1} pwm_mode_e;
  typedef enum logic {DIR_UP = 1'b0, DIR_DOWN = 1'b1} pwm_dir_e;
  localparam int unsigned N_SHD = 2;
  localparam int unsigned SHD_PER = 0;
  localparam int unsigned SHD_CMP = 1;
endpackage

// File: rtl/pwm_prescaler.sv
module pwm_prescaler #(
  parameter int unsigned PW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          restart_i,
  input  logic [PW-1:0] div_i,
  output logic          tick_o
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] cnt_q;
  logic          hit;

  assign hit    = cnt_q >= div_i;
  assign tick_o = run_i & hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || restart_i || hit) cnt_q <= '0;
    else cnt_q <= cnt_q + ONE;
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (!tick_o || div_i == '0));
endmodule

// File: rtl/pwm_shadow.sv
module pwm_shadow
  import pwm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      wr_per_i,
  input  logic      wr_cmp_i,
  input  logic [W-1:0] wdata_i,
  input  pwm_mode_e mode_i,
  input  logic      load_i,
  output logic [W-1:0] per_o,
  output logic [W-1:0] cmp_o,
  output pwm_mode_e mode_o
);
  logic [N_SHD-1:0] wr;
  logic [W-1:0]     shd_q [N_SHD];
  logic [W-1:0]     act_q [N_SHD];

  assign wr[SHD_PER] = wr_per_i;
  assign wr[SHD_CMP] = wr_cmp_i;

  for (genvar g = 0; g < N_SHD; g++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        shd_q[g] <= '0;
        act_q[g] <= '0;
      end else begin
        if (wr[g])  shd_q[g] <= wdata_i;
        if (load_i) act_q[g] <= shd_q[g];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     mode_o <= MODE_EDGE;
    else if (load_i) mode_o <= mode_i;
  end

  assign per_o = act_q[SHD_PER];
  assign cmp_o = act_q[SHD_CMP];

  // R3
  act_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> ($stable(per_o) && $stable(cmp_o) && $stable(mode_o)));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      active_i,
  input  logic      tick_i,
  input  logic      restart_i,
  input  logic [W-1:0] per_i,
  input  pwm_mode_e mode_i,
  output logic [W-1:0] cnt_o,
  output logic      start_o,
  output logic      load_o
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_q;
  pwm_dir_e     dir_q;
  logic         wrap;

  // center mode with P<=1 has no distinct down leg
  always_comb begin
    if (mode_i == MODE_EDGE)  wrap = cnt_q >= per_i;
    else if (dir_q == DIR_UP) wrap = (cnt_q >= per_i) && (per_i <= ONE);
    else                      wrap = cnt_q <= ONE;
  end

  assign start_o = active_i & (restart_i | (tick_i & wrap));
  assign load_o  = !active_i | start_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (load_o) begin
      cnt_q <= '0;
      dir_q <= DIR_UP;
    end else if (tick_i) begin
      if (mode_i == MODE_EDGE || (dir_q == DIR_UP && cnt_q < per_i)) begin
        cnt_q <= cnt_q + ONE;
      end else begin
        cnt_q <= cnt_q - ONE;
        dir_q <= DIR_DOWN;
      end
    end
  end

  assign cnt_o = cnt_q;

  // R1
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_i |-> cnt_q <= per_i);
  // R5
  dir_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_q == DIR_DOWN |-> mode_i == MODE_CENTER);
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwm_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             center_i,
  input  logic             master_i,
  input  logic [PSC_W-1:0] psc_i,
  input  logic             wr_per_i,
  input  logic             wr_cmp_i,
  input  logic [W-1:0]     wdata_i,
  input  logic             sync_i,
  output logic             pwm_o,
  output logic [W-1:0]     cnt_o,
  output logic             update_o,
  output logic             trig_o
);
  logic         run_q, active, restart, tick, start, load, upd_q;
  logic [W-1:0] per_act, cmp_act;
  pwm_mode_e    mode_act;

  assign active  = en_i & run_q;
  assign restart = active & ~master_i & sync_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      upd_q <= 1'b0;
    end else begin
      run_q <= en_i;
      upd_q <= start;
    end
  end

  pwm_prescaler #(.PW(PSC_W)) u_psc (
    .clk_i, .rst_ni, .run_i(active), .restart_i(restart), .div_i(psc_i), .tick_o(tick)
  );

  pwm_shadow #(.W(W)) u_shd (
    .clk_i, .rst_ni, .wr_per_i, .wr_cmp_i, .wdata_i,
    .mode_i(pwm_mode_e'(center_i)), .load_i(load),
    .per_o(per_act), .cmp_o(cmp_act), .mode_o(mode_act)
  );

  pwm_counter #(.W(W)) u_cnt (
    .clk_i, .rst_ni, .active_i(active), .tick_i(tick), .restart_i(restart),
    .per_i(per_act), .mode_i(mode_act), .cnt_o, .start_o(start), .load_o(load)
  );

  assign pwm_o    = run_q & (cnt_o < cmp_act);
  assign update_o = upd_q;
  assign trig_o   = upd_q & master_i;

  // R7
  upd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    update_o |-> cnt_o == '0);
  // R6
  duty_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q && cmp_act > per_act) |-> pwm_o);
  // R6
  duty_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_act == '0 |-> !pwm_o);
  // R8
  trig_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig_o |-> update_o);
  // R10
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_q |-> (cnt_o == '0 && !pwm_o));
endmodule

// File: tb/tb_pwm_timebase.sv
module tb_pwm_timebase;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        en_i = 1'b0, center_i = 1'b0, master_i = 1'b1, sync_i = 1'b0;
  logic [15:0] psc_i = '0, wdata_i = '0;
  logic        wr_per_i = 1'b0, wr_cmp_i = 1'b0;
  logic        pwm_o, update_o, trig_o;
  logic [15:0] cnt_o;
  int total = 0, bad = 0;

  always #2.5 clk_i = ~clk_i;

  pwm_timebase dut (.*);

  task automatic check(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // all driving and sampling happens at negedge
  task automatic wr(input bit per, input int val);
    wdata_i = 16'(val);
    if (per) wr_per_i = 1'b1; else wr_cmp_i = 1'b1;
    @(negedge clk_i);
    wr_per_i = 1'b0;
    wr_cmp_i = 1'b0;
  endtask

  task automatic wait_update();
    int n = 0;
    do begin @(negedge clk_i); n++; end while (!update_o && n < 5000);
  endtask

  // starts on an update sample, ends on the next one
  task automatic measure(output int len, output int hi, output int tr, output int pk);
    len = 0; hi = 0; tr = 0; pk = 0;
    do begin
      if (pwm_o) hi++;
      if (trig_o) tr++;
      if (int'(cnt_o) > pk) pk = int'(cnt_o);
      len++;
      @(negedge clk_i);
    end while (!update_o && len < 5000);
  endtask

  task automatic t_reset();
    check("R12 cnt", int'(cnt_o), 0);
    check("R12 pwm", int'(pwm_o), 0);
    check("R12 upd", int'(update_o), 0);
    check("R12 trig", int'(trig_o), 0);
  endtask

  task automatic t_edge();
    int len, hi, tr, pk, n;
    wr(1, 9);
    wr(0, 4);
    en_i = 1'b1;
    @(negedge clk_i);
    n = 0;
    while (!update_o && n < 100) begin n++; @(negedge clk_i); end
    check("R10 first cycle", n, 10);
    measure(len, hi, tr, pk);
    check("R1 len", len, 10);
    check("R1 peak", pk, 9);
    check("R4 hi", hi, 4);
    check("R8 master trig", tr, 1);
    check("R7 upd cnt", int'(cnt_o), 0);
  endtask

  task automatic t_shadow();
    int len, hi, tr, pk;
    fork
      measure(len, hi, tr, pk);
      begin wr(0, 7); wr(1, 5); end
    join
    check("R3 len old", len, 10);
    check("R3 hi old", hi, 4);
    fork
      measure(len, hi, tr, pk);
      begin repeat (2) @(negedge clk_i); wr(0, 0); end
    join
    check("R3 len new", len, 6);
    check("R6 full", hi, 6);
    measure(len, hi, tr, pk);
    check("R6 zero", hi, 0);
  endtask

  task automatic t_psc();
    int len, hi, tr, pk;
    fork
      measure(len, hi, tr, pk);
      wr(0, 3);
    join
    psc_i = 16'd2;
    measure(len, hi, tr, pk);
    check("R2 len", len, 18);
    check("R2 hi", hi, 9);
    psc_i = 16'd0;
  endtask

  task automatic t_mode();
    int len, hi, tr, pk;
    fork
      measure(len, hi, tr, pk);
      begin center_i = 1'b1; wr(1, 4); wr(0, 2); end
    join
    check("R11 len old", len, 6);
    check("R11 hi old", hi, 3);
    fork
      measure(len, hi, tr, pk);
      begin center_i = 1'b0; wr(1, 9); wr(0, 4); end
    join
    check("R5 len", len, 8);
    check("R5 hi", hi, 3);
    check("R5 peak", pk, 4);
    measure(len, hi, tr, pk);
    check("R11 back to edge", len, 10);
  endtask

  task automatic t_sync();
    int len, hi, tr, pk;
    repeat (3) @(negedge clk_i);
    sync_i = 1'b1;
    @(negedge clk_i);
    sync_i = 1'b0;
    check("R9 master ignores sync", int'(cnt_o), 4);
    check("R9 no upd", int'(update_o), 0);
    master_i = 1'b0;
    wait_update();
    measure(len, hi, tr, pk);
    check("R8 slave trig", tr, 0);
    repeat (3) @(negedge clk_i);
    sync_i = 1'b1;
    @(negedge clk_i);
    sync_i = 1'b0;
    check("R9 restart cnt", int'(cnt_o), 0);
    check("R9 restart upd", int'(update_o), 1);
    check("R8 slave trig low", int'(trig_o), 0);
    measure(len, hi, tr, pk);
    check("R9 len after sync", len, 10);
  endtask

  task automatic t_disable();
    int len, hi, tr, pk, n;
    repeat (2) @(negedge clk_i);
    en_i = 1'b0;
    @(negedge clk_i);
    check("R10 cnt idle", int'(cnt_o), 0);
    check("R10 pwm idle", int'(pwm_o), 0);
    wr(1, 3);
    wr(0, 2);
    check("R10 no upd idle", int'(update_o), 0);
    en_i = 1'b1;
    @(negedge clk_i);
    check("R10 start zero", int'(cnt_o), 0);
    n = 0;
    while (!update_o && n < 100) begin n++; @(negedge clk_i); end
    check("R10 load while idle", n, 4);
    measure(len, hi, tr, pk);
    check("R10 len", len, 4);
    check("R4 hi small", hi, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_edge();
    t_shadow();
    t_psc();
    t_mode();
    t_sync();
    t_disable();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500000;
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule